// File: doc/BRIEF.md
# SD Card SPI Command Frame Engine

This block issues a single SD-card command over an SPI link one byte at a time and captures the card's reply. A host presents a request: a 6-bit command index, a 32-bit argument, a check byte, a flag for a long reply and a flag to keep the card selected. The engine lowers chip-select and clocks one idle byte. It then sends the six-byte frame and polls the card with idle bytes until a byte with its top bit clear comes back. That byte is the status byte. If the host asked for a long reply, the engine also collects four more bytes into a 32-bit word.

After the reply, or after the poll budget runs out, the engine raises chip-select and clocks one more idle byte. When the keep-selected flag is set and a valid status arrived, it skips that step and leaves the card selected, so a block read can follow directly. The engine controls an external byte shifter through a start/done handshake. It never has more than one byte in flight.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset: cs_n is 1, busy is 0, spi_start is 0, rsp_done is 0, rsp_timeout is 0 and rsp_status reads 0xFF.
- R2: An accepted request drives cs_n low and clocks one 0xFF byte. It then sends, in order: 0x40 ORed with the command index; the argument most-significant byte first; the check byte with bit 0 forced to 1.
- R3: A request whose check byte is 0x00 selects the check byte automatically. Index 8 with argument 0x000001AA gets 0x87; any other command gets 0x95.
- R4: After the frame the engine sends 0xFF bytes. Received bytes with bit 7 set are skipped. The first received byte with bit 7 clear is reported on rsp_status, with rsp_timeout low.
- R5: If POLL_MAX (default 5000) polling bytes pass with no valid byte, the engine reports rsp_timeout high and rsp_status 0xFF.
- R6: After a status byte without the keep flag, or after any timeout, cs_n goes high and exactly one further 0xFF byte is clocked with cs_n high before rsp_done.
- R7: With the long flag set, four further 0xFF bytes are clocked after the status byte. The first byte received lands in rsp_tail[31:24] and the last in rsp_tail[7:0]. Without the flag, rsp_tail reads 0.
- R8: With the keep flag set and a valid status, cs_n stays low after rsp_done and no trailing byte is sent. The keep flag has no effect on a timeout.
- R9: A request presented while busy is ignored: the current frame continues unchanged and only one rsp_done results.
- R10: spi_start is never raised in two consecutive cycles. A new byte starts only after spi_done for the previous byte.
- R11: rsp_done is a one-cycle pulse per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_crc | input | 8 | Check byte; 0x00 selects it automatically |
| req_long | input | 1 | Collect a four-byte tail after the status |
| req_hold | input | 1 | Keep chip-select low after a valid status |
| busy | output | 1 | Command in progress |
| cs_n | output | 1 | Card chip-select, active low |
| spi_start | output | 1 | Start one byte exchange on the shifter |
| spi_tx | output | 8 | Byte to send |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| spi_done | input | 1 | Shifter finished the byte exchange |
| rsp_status | output | 8 | Status byte, or 0xFF on timeout |
| rsp_tail | output | 32 | Four-byte tail, first byte most significant |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | No valid status within the poll budget |

## Verification
The bench feeds replies that open with bytes whose top bit is set, such as 0xFE. A design that took the first non-0xFF byte would report the wrong status. It runs the full 5000-byte poll with no reply. Stopping one byte early or late, or leaving the status from the previous command, would change the byte count or rsp_status. It sets the keep flag both on a good reply and on a timeout. A design that always kept the card selected, or never did, would leave cs_n wrong or send an extra trailing byte. It also fires a second request in mid-frame. A design that latched it would corrupt the sent bytes or pulse done twice.

// File: rtl/sdcmd_pkg.sv
// Shared types and constants for the SD command frame engine.
// Assumes byte-wide SPI exchanges controlled by a start/done handshake.
package sdcmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_FRAME,
        ST_POLL,
        ST_TAIL,
        ST_TRAIL
    } sdcmd_state_e;

    localparam logic [7:0] FILL_BYTE    = 8'hFF;
    localparam logic [7:0] CMD_MARK     = 8'h40;
    localparam logic [7:0] CRC_DEFAULT  = 8'h95;
    localparam logic [7:0] CRC_IFCOND   = 8'h87;
endpackage

// File: rtl/sdcmd_frame.sv
// Byte selector for the command frame.
// sel 0 gives the start byte, sel 1..ARG_BYTES give the argument bytes
// most significant first, and the final position gives the check byte.
// Assumes sel stays within the frame length.
module sdcmd_frame #(
    parameter int IDX_W     = 6,
    parameter int ARG_W     = 32,
    parameter int SEL_W     = 4,
    parameter int AUTO_IDX  = 8,
    parameter logic [31:0] AUTO_ARG = 32'h0000_01AA
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    input  logic [7:0]       crc_in,
    input  logic [SEL_W-1:0] sel,
    output logic [7:0]       frame_byte
);
    import sdcmd_pkg::*;

    localparam int ARG_BYTES = ARG_W / 8;

    logic [7:0] arg_bytes [ARG_BYTES];
    logic [7:0] crc_eff;

    // Split the argument into bytes, most significant first.
    for (genvar g = 0; g < ARG_BYTES; g++) begin : g_argb
        assign arg_bytes[g] = arg[ARG_W-1-8*g -: 8];
    end

    // Pick the check byte: automatic when zero, else the given byte with bit 0 set.
    always_comb begin
        if (crc_in == 8'h00)
            crc_eff = (idx == IDX_W'(AUTO_IDX) && arg == ARG_W'(AUTO_ARG))
                      ? CRC_IFCOND : CRC_DEFAULT;
        else
            crc_eff = crc_in | 8'h01;
    end

    // Choose the byte for the current frame position.
    always_comb begin
        frame_byte = crc_eff;
        if (sel == '0)
            frame_byte = CMD_MARK | 8'(idx);
        for (int k = 0; k < ARG_BYTES; k++)
            if (sel == SEL_W'(k + 1))
                frame_byte = arg_bytes[k];
    end
endmodule

// File: rtl/sdcmd_poll.sv
// Poll budget counter: counts invalid reply bytes and flags the last one.
// Assumes clear is held while not polling.
module sdcmd_poll #(
    parameter int LIMIT = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count polled bytes that carried no valid status.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sdcmd_engine.sv
// SD card SPI command engine: sends one command frame and captures the reply.
// Assumes the byte shifter raises spi_done at least one cycle after spi_start
// and presents spi_rx together with spi_done.
module sdcmd_engine #(
    parameter int IDX_W      = 6,
    parameter int ARG_W      = 32,
    parameter int TAIL_BYTES = 4,
    parameter int POLL_MAX   = 5000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [IDX_W-1:0]      req_index,
    input  logic [ARG_W-1:0]      req_arg,
    input  logic [7:0]            req_crc,
    input  logic                  req_long,
    input  logic                  req_hold,
    output logic                  busy,
    output logic                  cs_n,
    output logic                  spi_start,
    output logic [7:0]            spi_tx,
    input  logic [7:0]            spi_rx,
    input  logic                  spi_done,
    output logic [7:0]            rsp_status,
    output logic [8*TAIL_BYTES-1:0] rsp_tail,
    output logic                  rsp_done,
    output logic                  rsp_timeout
);
    import sdcmd_pkg::*;

    localparam int FRAME_BYTES = 2 + ARG_W / 8;
    localparam int TAIL_W      = 8 * TAIL_BYTES;
    localparam int SEL_W       = $clog2(FRAME_BYTES + TAIL_BYTES);
    localparam logic [SEL_W-1:0] FRAME_LAST = SEL_W'(FRAME_BYTES - 1);
    localparam logic [SEL_W-1:0] TAIL_LAST  = SEL_W'(TAIL_BYTES - 1);

    sdcmd_state_e       st;
    logic               pend;
    logic [SEL_W-1:0]   sel;
    logic               cs_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ARG_W-1:0]   arg_q;
    logic [7:0]         crc_q;
    logic               long_q;
    logic               hold_q;
    logic [7:0]         status_q;
    logic [TAIL_W-1:0]  tail_q;
    logic               to_q;
    logic               done_q;
    logic [7:0]         frame_byte;
    logic               poll_last;
    logic               byte_end;

    sdcmd_frame #(
        .IDX_W (IDX_W),
        .ARG_W (ARG_W),
        .SEL_W (SEL_W)
    ) u_frame (
        .idx        (idx_q),
        .arg        (arg_q),
        .crc_in     (crc_q),
        .sel        (sel),
        .frame_byte (frame_byte)
    );

    sdcmd_poll #(
        .LIMIT (POLL_MAX)
    ) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st != ST_POLL),
        .step  (byte_end && spi_rx[7]),
        .last  (poll_last)
    );

    assign byte_end = (st != ST_IDLE) && pend && spi_done;

    // Sequence the command: lead byte, frame, poll, tail, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            pend     <= 1'b0;
            sel      <= '0;
            cs_q     <= 1'b1;
            idx_q    <= '0;
            arg_q    <= '0;
            crc_q    <= '0;
            long_q   <= 1'b0;
            hold_q   <= 1'b0;
            status_q <= FILL_BYTE;
            tail_q   <= '0;
            to_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st == ST_IDLE) begin
                if (req_valid) begin
                    idx_q  <= req_index;
                    arg_q  <= req_arg;
                    crc_q  <= req_crc;
                    long_q <= req_long;
                    hold_q <= req_hold;
                    cs_q   <= 1'b0;
                    tail_q <= '0;
                    to_q   <= 1'b0;
                    pend   <= 1'b0;
                    st     <= ST_LEAD;
                end
            end else if (!pend) begin
                pend <= 1'b1;
            end else if (spi_done) begin
                pend <= 1'b0;
                case (st)
                    ST_LEAD: begin
                        sel <= '0;
                        st  <= ST_FRAME;
                    end
                    ST_FRAME: begin
                        if (sel == FRAME_LAST) st <= ST_POLL;
                        else                   sel <= sel + 1'b1;
                    end
                    ST_POLL: begin
                        if (!spi_rx[7]) begin
                            status_q <= spi_rx;
                            if (long_q) begin
                                sel <= '0;
                                st  <= ST_TAIL;
                            end else if (hold_q) begin
                                done_q <= 1'b1;
                                st     <= ST_IDLE;
                            end else begin
                                cs_q <= 1'b1;
                                st   <= ST_TRAIL;
                            end
                        end else if (poll_last) begin
                            status_q <= FILL_BYTE;
                            to_q     <= 1'b1;
                            cs_q     <= 1'b1;
                            st       <= ST_TRAIL;
                        end
                    end
                    ST_TAIL: begin
                        tail_q <= {tail_q[TAIL_W-9:0], spi_rx};
                        if (sel != TAIL_LAST) begin
                            sel <= sel + 1'b1;
                        end else if (hold_q) begin
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            cs_q <= 1'b1;
                            st   <= ST_TRAIL;
                        end
                    end
                    ST_TRAIL: begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Drive the shifter and the reply outputs.
    assign spi_start   = (st != ST_IDLE) && !pend;
    assign spi_tx      = (st == ST_FRAME) ? frame_byte : FILL_BYTE;
    assign busy        = (st != ST_IDLE);
    assign cs_n        = cs_q;
    assign rsp_status  = status_q;
    assign rsp_tail    = tail_q;
    assign rsp_done    = done_q;
    assign rsp_timeout = to_q;
endmodule

// File: rtl/sdcmd_engine_chk.sv
// Protocol checker for the SD command engine, bound to every instance.
// Assumes synchronous active-low reset.
module sdcmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cs_n,
    input logic       spi_start,
    input logic       rsp_done,
    input logic       rsp_timeout,
    input logic [7:0] rsp_status
);
    assert_single_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start |=> !spi_start);

    assert_no_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_start);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_timeout_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_timeout) |-> (rsp_status == 8'hFF));

    assert_valid_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_timeout) |-> !rsp_status[7]);

    assert_release_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_timeout) |-> cs_n);
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .cs_n        (cs_n),
    .spi_start   (spi_start),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout),
    .rsp_status  (rsp_status)
);

// File: tb/tb_sdcmd_engine.sv
// Directed bench for the SD command engine with a behavioural byte shifter.
module tb_sdcmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_index = '0;
    logic [31:0] req_arg = '0;
    logic [7:0]  req_crc = '0;
    logic        req_long = 1'b0;
    logic        req_hold = 1'b0;
    logic        busy, cs_n, spi_start, rsp_done, rsp_timeout;
    logic [7:0]  spi_tx, rsp_status;
    logic [7:0]  spi_rx = 8'hFF;
    logic        spi_done = 1'b0;
    logic [31:0] rsp_tail;

    int errors = 0;
    int checks = 0;

    // shifter model state
    logic [7:0] scr [16];
    int         scr_len = 0;
    logic [7:0] log_tx [16];
    logic       log_cs [16];
    int         nlog = 0;
    logic       last_cs = 1'b1;
    logic       prev_cs = 1'b1;
    int         done_cnt = 0;

    always #2 clk = ~clk;

    sdcmd_engine dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_arg(req_arg), .req_crc(req_crc), .req_long(req_long), .req_hold(req_hold),
        .busy(busy), .cs_n(cs_n), .spi_start(spi_start), .spi_tx(spi_tx),
        .spi_rx(spi_rx), .spi_done(spi_done), .rsp_status(rsp_status),
        .rsp_tail(rsp_tail), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout)
    );

    function automatic logic [7:0] reply_for(int n);
        if (n >= 7 && (n - 7) < scr_len) return scr[n-7];
        return 8'hFF;
    endfunction

    // Byte shifter: log each started byte, answer one cycle later.
    initial begin
        forever begin
            @(negedge clk);
            spi_done = 1'b0;
            if (spi_start) begin
                logic [7:0] rv;
                if (nlog < 16) begin
                    log_tx[nlog] = spi_tx;
                    log_cs[nlog] = cs_n;
                end
                prev_cs = last_cs;
                last_cs = cs_n;
                rv = reply_for(nlog);
                nlog++;
                @(negedge clk);
                spi_done = 1'b1;
                spi_rx   = rv;
            end
        end
    end

    // Count completion pulses.
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_done) done_cnt++;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(logic [5:0] ix, logic [31:0] ar, logic [7:0] cr, logic lg, logic hd);
        nlog = 0;
        @(negedge clk);
        req_index = ix; req_arg = ar; req_crc = cr; req_long = lg; req_hold = hd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!rsp_done) @(negedge clk);
    endtask

    task automatic chk_frame(string tag, logic [5:0] ix, logic [31:0] ar, logic [7:0] cr);
        chk({tag, " lead byte"}, {24'h0, log_tx[0]}, 32'hFF);
        chk({tag, " lead cs low"}, {31'h0, log_cs[0]}, 32'h0);
        chk({tag, " cmd byte"}, {24'h0, log_tx[1]}, {24'h0, 8'h40 | {2'b00, ix}});
        chk({tag, " arg"}, {log_tx[2], log_tx[3], log_tx[4], log_tx[5]}, ar);
        chk({tag, " crc"}, {24'h0, log_tx[6]}, {24'h0, cr});
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 cs_n", {31'h0, cs_n}, 32'h1);
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 spi_start", {31'h0, spi_start}, 32'h0);
        chk("R1 rsp_done", {31'h0, rsp_done}, 32'h0);
        chk("R1 rsp_timeout", {31'h0, rsp_timeout}, 32'h0);
        chk("R1 rsp_status", {24'h0, rsp_status}, 32'hFF);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2 R4 R6: basic command with forced check bit and skipped bytes
    task automatic t_basic();
        scr[0] = 8'hFF; scr[1] = 8'hFF; scr[2] = 8'h00; scr_len = 3;
        send(6'd17, 32'h1234_5678, 8'h32, 1'b0, 1'b0);
        wait_done();
        chk_frame("R2 basic", 6'd17, 32'h1234_5678, 8'h33);
        chk("R4 status", {24'h0, rsp_status}, 32'h00);
        chk("R4 no timeout", {31'h0, rsp_timeout}, 32'h0);
        chk("R6 byte count", nlog, 11);
        chk("R6 trail cs high", {31'h0, last_cs}, 32'h1);
        chk("R6 last poll cs low", {31'h0, prev_cs}, 32'h0);
        chk("R6 cs_n after", {31'h0, cs_n}, 32'h1);
        chk("R7 short tail zero", rsp_tail, 32'h0);
        @(negedge clk);
        chk("R11 done pulse low", {31'h0, rsp_done}, 32'h0);
    endtask

    // R3 R4 R7: automatic check byte and long reply
    task automatic t_auto_long();
        scr[0] = 8'h01; scr_len = 1;
        send(6'd0, 32'h0, 8'h00, 1'b0, 1'b0);
        wait_done();
        chk_frame("R3 auto reset cmd", 6'd0, 32'h0, 8'h95);
        chk("R4 idle status", {24'h0, rsp_status}, 32'h01);
        scr[0] = 8'hFE; scr[1] = 8'h01; scr[2] = 8'h00; scr[3] = 8'h00;
        scr[4] = 8'h01; scr[5] = 8'hAA; scr_len = 6;
        send(6'd8, 32'h0000_01AA, 8'h00, 1'b1, 1'b0);
        wait_done();
        chk_frame("R3 auto cond cmd", 6'd8, 32'h0000_01AA, 8'h87);
        chk("R4 skip top-bit byte", {24'h0, rsp_status}, 32'h01);
        chk("R7 tail word", rsp_tail, 32'h0000_01AA);
        chk("R7 byte count", nlog, 14);
        scr[0] = 8'h05; scr_len = 1;
        send(6'd8, 32'h0000_01AB, 8'h00, 1'b0, 1'b0);
        wait_done();
        chk("R3 other arg crc", {24'h0, log_tx[6]}, 32'h95);
        chk("R4 status 05", {24'h0, rsp_status}, 32'h05);
    endtask

    // R8: keep-selected after a valid reply, then a normal command releases
    task automatic t_hold();
        scr[0] = 8'h00; scr_len = 1;
        send(6'd17, 32'h0000_0200, 8'h01, 1'b0, 1'b1);
        wait_done();
        chk("R8 byte count no trail", nlog, 8);
        @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R8 cs stays low", {31'h0, cs_n}, 32'h0);
        chk("R8 no extra byte", nlog, 8);
        scr[0] = 8'h00; scr_len = 1;
        send(6'd13, 32'h0, 8'h00, 1'b0, 1'b0);
        wait_done();
        chk("R6 release after hold", {31'h0, cs_n}, 32'h1);
        chk("R6 release byte count", nlog, 9);
    endtask

    // R5 R8: timeout ignores keep flag
    task automatic t_timeout();
        scr_len = 0;
        send(6'd41, 32'h4000_0000, 8'h00, 1'b0, 1'b1);
        wait_done();
        chk("R5 timeout flag", {31'h0, rsp_timeout}, 32'h1);
        chk("R5 status FF", {24'h0, rsp_status}, 32'hFF);
        chk("R5 byte count", nlog, 7 + 5000 + 1);
        chk("R8 timeout releases", {31'h0, cs_n}, 32'h1);
        scr[0] = 8'h00; scr_len = 1;
        send(6'd55, 32'h0, 8'h00, 1'b0, 1'b0);
        wait_done();
        chk("R5 flag cleared on next", {31'h0, rsp_timeout}, 32'h0);
        chk("R4 fresh status", {24'h0, rsp_status}, 32'h00);
    endtask

    // R9 R11: request while busy is ignored
    task automatic t_ignore();
        int base;
        base = done_cnt;
        scr[0] = 8'h00; scr_len = 1;
        send(6'd24, 32'h0000_0010, 8'h00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        req_index = 6'd9; req_arg = 32'hFFFF_FFFF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk_frame("R9 frame unchanged", 6'd24, 32'h0000_0010, 8'h95);
        repeat (20) @(negedge clk);
        chk("R9 one done", done_cnt - base, 1);
        chk("R9 idle after", {31'h0, busy}, 32'h0);
        chk("R11 single pulse count", nlog, 9);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_auto_long();
        t_hold();
        t_timeout();
        t_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule